// File: doc/BRIEF.md
# PAM4 Decision Feedback Equalizer with Relocatable Tap Groups

This block equalizes a stream of digitized PAM4 receiver samples. Each accepted signed sample has the weighted sum of earlier symbol decisions removed from it. The result is sliced to one of four levels, and the block returns both the Gray-coded symbol and the equalized sample value. Postcursor cancellation uses twelve contiguous taps that cover the most recent decisions. It also uses three groups of three adjacent taps, and each group can be placed anywhere in a 40-symbol decision history. This lets a group follow a late reflection in the channel.

Tap weights and group placements are written through a simple configuration port. Every written value is forced into the legal range for its tap class. A read returns the value that was stored after clamping. The slicer thresholds scale with a programmable signal amplitude. Coefficient adaptation is done outside the block.

Top module: `dfe_pam4_floating`

## Requirements
- R1: `in_ready` is always 1. A sample accepted with `in_valid` high gives `out_valid` high on the next cycle. `out_valid` is low in the cycle after any cycle without `in_valid`.
- R2: With amplitude A, an equalized value y is sliced to +3 when y >= 2A, to +1 when 0 <= y < 2A, to -1 when -2A <= y < 0, and to -3 when y < -2A. `out_symbol` encodes -3, -1, +1 and +3 as 00, 01, 11 and 10.
- R3: `out_eq` = sample - floor(S*A/256). S is the sum over all taps of coefficient times the past decision level at that tap's delay. Coefficients are signed with 8 fractional bits.
- R4: Configuration addresses 0 to 11 hold fixed taps 1 to 12. Fixed tap n weights the decision made n samples earlier.
- R5: Fixed tap writes are clamped. Tap 1 is held to [-12, 217], taps 2 and 3 to [-12, 76], and taps 4 to 12 to [-12, 51]. A read returns the clamped value.
- R6: Address 12+3g+k holds tap k (0..2) of group g (0..2). Writes to these addresses are clamped to [-12, 12].
- R7: Address 21+g holds the start delay s of group g. The start delay is taken from `cfg_wdata[5:0]` as an unsigned value and saturated to 13..38. The group's taps then sit at delays s, s+1 and s+2, and a read returns s.
- R8: Where two groups cover the same delay, their coefficients at that delay add. `grp_overlap` is high exactly while any two groups share a delay.
- R9: Reset clears the decision history to zero, all coefficients to 0, the group starts to 13, 19 and 25, and `out_valid` to 0.
- R10: The decision history advances only on accepted samples. Idle cycles leave it unchanged. Writes to addresses 24 to 31 are ignored, and reads from those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Block accepts a sample (always 1) |
| in_sample | input | 12 | Signed ADC sample |
| amp | input | 11 | Unsigned level amplitude A |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration address, also used for read |
| cfg_wdata | input | 9 | Write data (signed coefficient or start delay) |
| cfg_rdata | output | 9 | Stored value at `cfg_addr` |
| out_valid | output | 1 | Output present |
| out_symbol | output | 2 | Gray-coded decision |
| out_eq | output | 20 | Signed equalized sample |
| grp_overlap | output | 1 | Two tap groups share a delay |

## Verification
The hardest state to reach from the ports is an overlap of two floating groups at delays near 30. In that state the result depends on the sum of both groups' coefficients acting on a decision made about thirty samples earlier. The stimulus places two groups one delay apart, with weights near their clamp limits. It then sends more than 40 pseudo-random samples so that the whole history holds known non-zero decisions. Every output is compared with a model that the bench builds from the requirements alone. The groups are then moved apart, and the bench checks that the overlap flag drops.

// File: rtl/dfe_pkg.sv
// Shared types and coefficient bounds for the PAM4 decision feedback equalizer.
// Assumes coefficients are signed fixed-point values with COEF_FRAC fractional bits.
package dfe_pkg;
    localparam int COEF_W    = 9;
    localparam int COEF_FRAC = 8;

    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [2:0]        lvl_t;

    // Convert a bound in hundredths to fixed point, truncating toward zero.
    function automatic int frac_bound(input int hundredths);
        return (hundredths * (1 << COEF_FRAC)) / 100;
    endfunction

    localparam int C_MIN     = -frac_bound(5);
    localparam int C_MAX_T1  = frac_bound(85);
    localparam int C_MAX_T23 = frac_bound(30);
    localparam int C_MAX_FIX = frac_bound(20);
    localparam int C_MAX_FLT = frac_bound(5);

    // Force a coefficient into [lo, hi].
    function automatic coef_t clamp_coef(input coef_t v, input int hi, input int lo);
        if (int'(v) > hi) return coef_t'(hi);
        if (int'(v) < lo) return coef_t'(lo);
        return v;
    endfunction
endpackage

// File: rtl/dfe_cfg_regs.sv
// Configuration store: fixed tap weights, floating group weights and group start delays.
// Every write is clamped or saturated before storage, and reads are combinational.
// Assumes the address map is fixed taps first, then group weights, then group starts.
module dfe_cfg_regs
    import dfe_pkg::*;
#(
    parameter int N_FIXED    = 12,
    parameter int N_GROUPS   = 3,
    parameter int GROUP_LEN  = 3,
    parameter int HIST_DEPTH = 40,
    parameter int ADDR_W     = 5,
    parameter int POS_W      = 6
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cfg_we,
    input  logic [ADDR_W-1:0]                  cfg_addr,
    input  coef_t                              cfg_wdata,
    output coef_t                              cfg_rdata,
    output coef_t [N_FIXED-1:0]                fixed_c,
    output coef_t [N_GROUPS*GROUP_LEN-1:0]     flt_c,
    output logic  [N_GROUPS-1:0][POS_W-1:0]    grp_start,
    output logic                               grp_overlap
);
    localparam int N_FLT     = N_GROUPS * GROUP_LEN;
    localparam int FLT_BASE  = N_FIXED;
    localparam int POS_BASE  = FLT_BASE + N_FLT;
    localparam int START_MIN = N_FIXED + 1;
    localparam int START_MAX = HIST_DEPTH - GROUP_LEN + 1;
    localparam int START_GAP = GROUP_LEN * 2;

    // Saturate a raw start value into the legal range.
    function automatic logic [POS_W-1:0] sat_start(input logic [POS_W-1:0] p);
        if (int'(p) < START_MIN) return POS_W'(START_MIN);
        if (int'(p) > START_MAX) return POS_W'(START_MAX);
        return p;
    endfunction

    genvar i;
    generate
        for (i = 0; i < N_FIXED; i++) begin : g_fixed
            localparam int HI = (i == 0) ? C_MAX_T1 : (i < 3) ? C_MAX_T23 : C_MAX_FIX;
            // Store a clamped fixed tap weight.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    fixed_c[i] <= '0;
                else if (cfg_we && cfg_addr == ADDR_W'(i))
                    fixed_c[i] <= clamp_coef(cfg_wdata, HI, C_MIN);
            end
        end
        for (i = 0; i < N_FLT; i++) begin : g_flt
            // Store a clamped floating tap weight.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    flt_c[i] <= '0;
                else if (cfg_we && cfg_addr == ADDR_W'(FLT_BASE + i))
                    flt_c[i] <= clamp_coef(cfg_wdata, C_MAX_FLT, C_MIN);
            end
        end
        for (i = 0; i < N_GROUPS; i++) begin : g_pos
            // Store a saturated group start delay; groups reset to staggered places.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    grp_start[i] <= POS_W'(START_MIN + i * START_GAP);
                else if (cfg_we && cfg_addr == ADDR_W'(POS_BASE + i))
                    grp_start[i] <= sat_start(cfg_wdata[POS_W-1:0]);
            end
        end
    endgenerate

    // Read mux over all stored values; unmapped addresses read zero.
    always_comb begin
        cfg_rdata = '0;
        for (int a = 0; a < N_FIXED; a++)
            if (cfg_addr == ADDR_W'(a)) cfg_rdata = fixed_c[a];
        for (int a = 0; a < N_FLT; a++)
            if (cfg_addr == ADDR_W'(FLT_BASE + a)) cfg_rdata = flt_c[a];
        for (int a = 0; a < N_GROUPS; a++)
            if (cfg_addr == ADDR_W'(POS_BASE + a)) cfg_rdata = coef_t'(grp_start[a]);
    end

    // Flag any pair of groups whose delay spans intersect.
    always_comb begin
        grp_overlap = 1'b0;
        for (int a = 0; a < N_GROUPS; a++)
            for (int b = a + 1; b < N_GROUPS; b++)
                if ((int'(grp_start[a]) - int'(grp_start[b]) < GROUP_LEN) &&
                    (int'(grp_start[b]) - int'(grp_start[a]) < GROUP_LEN))
                    grp_overlap = 1'b1;
    end

    // R5: a write to tap 1 leaves it inside its bounds.
    a_r5_tap1_clamped: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == '0) |=> (int'(fixed_c[0]) <= C_MAX_T1 && int'(fixed_c[0]) >= C_MIN));

    // R6: a write to the first floating weight leaves it inside its bounds.
    a_r6_flt_clamped: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == ADDR_W'(FLT_BASE)) |=> (int'(flt_c[0]) <= C_MAX_FLT && int'(flt_c[0]) >= C_MIN));

    // R7: group starts never leave the legal window.
    a_r7_start_range: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(grp_start[0]) >= START_MIN && int'(grp_start[0]) <= START_MAX &&
         int'(grp_start[N_GROUPS-1]) >= START_MIN && int'(grp_start[N_GROUPS-1]) <= START_MAX));

    // R10: writes are not allowed to disturb other addresses; no write means weights hold.
    a_r10_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(fixed_c) && $stable(flt_c) && $stable(grp_start)));
endmodule

// File: rtl/dfe_hist.sv
// Decision history: a shift register of past PAM4 levels, newest at index 0.
// Assumes the caller asserts shift_en only for accepted samples.
module dfe_hist
    import dfe_pkg::*;
#(
    parameter int HIST_DEPTH = 40
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       shift_en,
    input  lvl_t                       new_lvl,
    output lvl_t [HIST_DEPTH-1:0]      hist
);
    // Push the newest decision; reset empties the history to zero levels.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hist <= '0;
        else if (shift_en)
            hist <= {hist[HIST_DEPTH-2:0], new_lvl};
    end

    // R10: idle cycles leave the history untouched.
    a_r10_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(hist));

    // R4: one accepted sample moves every entry one delay further back.
    a_r4_hist_shift: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (hist[1] == $past(hist[0]) && hist[HIST_DEPTH-1] == $past(hist[HIST_DEPTH-2])));
endmodule

// File: rtl/dfe_slicer.sv
// Four-level slicer with thresholds at 0 and +/-2A, Gray-coded symbol output.
// Purely combinational; assumes amp is non-negative.
module dfe_slicer
    import dfe_pkg::*;
#(
    parameter int EQ_W  = 20,
    parameter int AMP_W = 11
) (
    input  logic signed [EQ_W-1:0] y,
    input  logic [AMP_W-1:0]       amp,
    output lvl_t                   lvl,
    output logic [1:0]             sym
);
    logic signed [EQ_W-1:0] thr;

    // Upper threshold is twice the amplitude.
    assign thr = EQ_W'({amp, 1'b0});

    // Pick the level and its Gray code from the thresholds.
    always_comb begin
        if (y >= thr) begin
            lvl = 3'sd3;  sym = 2'b10;
        end else if (y >= 0) begin
            lvl = 3'sd1;  sym = 2'b11;
        end else if (y >= -thr) begin
            lvl = -3'sd1; sym = 2'b01;
        end else begin
            lvl = -3'sd3; sym = 2'b00;
        end
    end
endmodule

// File: rtl/dfe_pam4_floating.sv
// PAM4 decision feedback equalizer with 12 fixed taps and three relocatable tap groups.
// Feedback, slicing and history update happen in the accepting cycle; the outputs are
// registered one cycle later. Assumes one sample per cycle at most and no output stall.
module dfe_pam4_floating
    import dfe_pkg::*;
#(
    parameter int SAMPLE_W   = 12,
    parameter int AMP_W      = 11,
    parameter int HIST_DEPTH = 40,
    parameter int N_FIXED    = 12,
    parameter int N_GROUPS   = 3,
    parameter int GROUP_LEN  = 3,
    localparam int EQ_W      = SAMPLE_W + 8,
    localparam int ADDR_W    = $clog2(N_FIXED + N_GROUPS * GROUP_LEN + N_GROUPS),
    localparam int POS_W     = $clog2(HIST_DEPTH + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [SAMPLE_W-1:0]        in_sample,
    input  logic [AMP_W-1:0]           amp,
    input  logic                       cfg_we,
    input  logic [ADDR_W-1:0]          cfg_addr,
    input  logic [COEF_W-1:0]          cfg_wdata,
    output logic [COEF_W-1:0]          cfg_rdata,
    output logic                       out_valid,
    output logic [1:0]                 out_symbol,
    output logic [EQ_W-1:0]            out_eq,
    output logic                       grp_overlap
);
    coef_t [N_FIXED-1:0]               fixed_c;
    coef_t [N_GROUPS*GROUP_LEN-1:0]    flt_c;
    logic  [N_GROUPS-1:0][POS_W-1:0]   grp_start;
    lvl_t  [HIST_DEPTH-1:0]            hist;
    coef_t                             rdata_c;
    lvl_t                              dec_lvl;
    logic  [1:0]                       dec_sym;
    logic signed [EQ_W-1:0]            y_eq;
    int                                acc;
    int                                fb;

    assign in_ready  = 1'b1;
    assign cfg_rdata = rdata_c;

    dfe_cfg_regs #(
        .N_FIXED(N_FIXED), .N_GROUPS(N_GROUPS), .GROUP_LEN(GROUP_LEN),
        .HIST_DEPTH(HIST_DEPTH), .ADDR_W(ADDR_W), .POS_W(POS_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(coef_t'(cfg_wdata)), .cfg_rdata(rdata_c), .fixed_c(fixed_c),
        .flt_c(flt_c), .grp_start(grp_start), .grp_overlap(grp_overlap)
    );

    dfe_hist #(.HIST_DEPTH(HIST_DEPTH)) u_hist (
        .clk(clk), .rst_n(rst_n), .shift_en(in_valid), .new_lvl(dec_lvl), .hist(hist)
    );

    // Weighted sum of past decisions over fixed taps and all group taps.
    always_comb begin
        acc = 0;
        for (int i = 0; i < N_FIXED; i++)
            acc += int'(fixed_c[i]) * int'(hist[i]);
        for (int g = 0; g < N_GROUPS; g++)
            for (int k = 0; k < GROUP_LEN; k++)
                acc += int'(flt_c[g*GROUP_LEN+k]) * int'(hist[int'(grp_start[g]) + k - 1]);
    end

    // Scale by amplitude, drop the fractional bits and subtract from the sample.
    always_comb begin
        fb   = (acc * int'({1'b0, amp})) >>> COEF_FRAC;
        y_eq = EQ_W'(int'($signed(in_sample)) - fb);
    end

    dfe_slicer #(.EQ_W(EQ_W), .AMP_W(AMP_W)) u_slice (
        .y(y_eq), .amp(amp), .lvl(dec_lvl), .sym(dec_sym)
    );

    // Register the decision and equalized value for the accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_symbol <= 2'b00;
            out_eq     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_symbol <= dec_sym;
                out_eq     <= y_eq;
            end
        end
    end

    // R1: an accepted sample yields an output one cycle later.
    a_r1_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R1: no sample, no output.
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R2: the top symbol only appears at or above the upper threshold.
    a_r2_top_symbol: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && amp == $past(amp)) |=>
        (out_symbol != 2'b10 || $signed(out_eq) >= $signed({1'b0, amp, 1'b0})));

    // R2: the bottom symbol only appears below the lower threshold.
    a_r2_bottom_symbol: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && amp == $past(amp)) |=>
        (out_symbol != 2'b00 || $signed(out_eq) < -$signed({1'b0, amp, 1'b0})));
endmodule

// File: tb/dfe_pam4_floating_bench.sv
// Bench for the PAM4 equalizer: a configuration vector table, then directed sample tests
// compared with a behavioural model built from the requirements.
module dfe_pam4_floating_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [11:0] in_sample = '0;
    logic [10:0] amp = 11'd32;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [8:0]  cfg_wdata = '0;
    logic [8:0]  cfg_rdata;
    logic        out_valid;
    logic [1:0]  out_symbol;
    logic [19:0] out_eq;
    logic        grp_overlap;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    int mfix[12];
    int mflt[9];
    int mst[3];
    int mh[41];
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    dfe_pam4_floating u_dfe_pam4_floating (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_sample(in_sample), .amp(amp), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .out_valid(out_valid),
        .out_symbol(out_symbol), .out_eq(out_eq), .grp_overlap(grp_overlap)
    );

    // {address, write data, expected read-back}
    localparam int TBL [12][3] = '{
        '{0, 255, 217}, '{0, -100, -12}, '{1, 100, 76}, '{2, -5, -5},
        '{5, 100, 51},  '{11, 40, 40},   '{12, 50, 12}, '{20, -30, -12},
        '{21, 5, 13},   '{22, 63, 38},   '{23, 30, 30}, '{27, 99, 0}
    };

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int clampi(input int v, input int hi, input int lo);
        return (v > hi) ? hi : (v < lo) ? lo : v;
    endfunction

    task automatic model_reset();
        foreach (mfix[i]) mfix[i] = 0;
        foreach (mflt[i]) mflt[i] = 0;
        mst[0] = 13; mst[1] = 19; mst[2] = 25;
        foreach (mh[i]) mh[i] = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; cfg_we = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic wr(input int a, input int d);
        int p;
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = 9'(d);
        @(negedge clk);
        cfg_we = 1'b0;
        if (a == 0) mfix[0] = clampi(d, 217, -12);
        else if (a < 3) mfix[a] = clampi(d, 76, -12);
        else if (a < 12) mfix[a] = clampi(d, 51, -12);
        else if (a < 21) mflt[a-12] = clampi(d, 12, -12);
        else if (a < 24) begin
            p = d & 63;
            mst[a-21] = clampi(p, 38, 13);
        end
    endtask

    task automatic rd(input string tag, input int a, input int exp);
        @(negedge clk);
        cfg_addr = 5'(a);
        #1;
        check(tag, int'($signed(cfg_rdata)), exp);
    endtask

    task automatic send(input string tag, input int x);
        int acc; int fb; int y; int lv; int sy;
        acc = 0;
        for (int i = 0; i < 12; i++) acc += mfix[i] * mh[i+1];
        for (int g = 0; g < 3; g++)
            for (int k = 0; k < 3; k++) acc += mflt[3*g+k] * mh[mst[g]+k];
        fb = (acc * int'(amp)) >>> 8;
        y = x - fb;
        if (y >= 2*int'(amp)) begin lv = 3; sy = 2; end
        else if (y >= 0) begin lv = 1; sy = 3; end
        else if (y >= -2*int'(amp)) begin lv = -1; sy = 1; end
        else begin lv = -3; sy = 0; end
        @(negedge clk);
        in_valid = 1'b1; in_sample = 12'(x);
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " valid R1"}, int'(out_valid), 1);
        check({tag, " symbol"}, int'(out_symbol), sy);
        check({tag, " eq"}, int'($signed(out_eq)), y);
        for (int d = 40; d >= 2; d--) mh[d] = mh[d-1];
        mh[1] = lv;
    endtask

    function automatic int next_x();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return int'(lfsr % 16'd401) - 200;
    endfunction

    initial begin
        model_reset();
        do_reset();
        // R9: reset state at the ports.
        check("R9 out_valid after reset", int'(out_valid), 0);
        check("R1 in_ready", int'(in_ready), 1);
        rd("R9 tap1 reset", 0, 0);
        rd("R9 group1 start reset", 22, 19);
        check("R9 no overlap at reset", int'(grp_overlap), 0);

        // R5 R6 R7 R10: configuration table walk.
        for (int t = 0; t < 12; t++) begin
            wr(TBL[t][0], TBL[t][1]);
            rd($sformatf("R5/R6/R7/R10 table row %0d", t), TBL[t][0], TBL[t][2]);
        end

        // R2: slicer thresholds with zero feedback, A = 32.
        do_reset();
        amp = 11'd32;
        send("R2 x=64", 64);
        send("R2 x=63", 63);
        send("R2 x=0", 0);
        send("R2 x=-1", -1);
        send("R2 x=-64", -64);
        send("R2 x=-65", -65);

        // R4 R3: fixed taps only, delay-3 tap alone, then a mix.
        do_reset();
        wr(2, 51);
        send("R4 delay3 seed", 100);
        send("R4 delay3 gap a", 0);
        send("R4 delay3 gap b", 0);
        send("R4 delay3 hit", 0);
        wr(0, 217); wr(1, 60); wr(11, -12); wr(6, 30);
        amp = 11'd48;
        for (int i = 0; i < 30; i++) send("R3 fixed random", next_x());

        // R7: one floating group deep in the history.
        wr(21, 30); wr(12, 12); wr(13, -12); wr(14, 6);
        rd("R7 start read", 21, 30);
        for (int i = 0; i < 45; i++) send("R7 floating random", next_x());

        // R8: two groups sharing delays 31 and 32.
        wr(22, 31); wr(15, 12); wr(16, 12); wr(17, -12);
        #1 check("R8 overlap flag set", int'(grp_overlap), 1);
        for (int i = 0; i < 45; i++) send("R8 overlap random", next_x());
        wr(22, 34);
        #1 check("R8 overlap flag clear", int'(grp_overlap), 0);
        send("R8 apart", next_x());

        // R10 R1: idle cycles neither shift history nor raise out_valid.
        send("R10 before idle", 150);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R1 idle out_valid", int'(out_valid), 0);
        end
        send("R10 after idle", -20);
        wr(26, 77);
        rd("R10 unmapped write ignored", 26, 0);
        send("R10 after unmapped write", 40);

        // R9: reset mid-stream empties history.
        do_reset();
        wr(0, 100);
        send("R9 history cleared", 10);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        done = 1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule